// File: doc/BRIEF.md
# Test-Access-Port Data Register Bank with Cascade Addressing

This block sits behind the TAP controller of a scan-chain multiplexer and holds its user data registers. On each test clock it takes the controller's capture, shift and update strobes together with TDI and the instruction held in the instruction register. It then moves data through a single shift stage and drives TDO with an output enable. Three registers are reachable: a read-only 8-bit identity code, a 6-bit configuration word, and a 32-bit scratchpad. The configuration and scratchpad contents are also presented as parallel outputs for the rest of the device.

Two identical devices can share one scan path. The top bit of the instruction then works as a device address, so that only one of them ever answers a given instruction. A static mode input says whether this device runs alone or in a cascade. A second one says whether it is the cascade master or the extension. When the device is not addressed, its TDO stays undriven and every strobe is ignored. When it is addressed but the instruction's low bits match no register, a one-bit bypass path is used.

Top module: `jtag_regbank`

## Requirements
- R1: With cascade_en high, a device with is_extension low answers only instructions whose top bit is 0. A device with is_extension high answers only instructions whose top bit is 1.
- R2: With cascade_en low, the device answers only instructions whose top bit is 0, whatever the value of is_extension.
- R3: When the low instruction bits are 001, capture loads the identity value: fixed code in bits 7:4 and revision in bits 3:0 (default 8'hA3).
- R4: An update with the identity register selected leaves the configuration and scratchpad outputs unchanged, and a later identity capture still yields the same value.
- R5: When the low instruction bits are 010, the 6-bit configuration register takes bits 5:0 of the shift stage on update, and capture loads it back.
- R6: When the low instruction bits are 011, the 32-bit scratchpad takes the full shift stage on update and is read back by capture. Reset clears it, together with the configuration register.
- R7: While the device is not addressed, capture, shift and update change neither the registers nor TDO, and tdo_oe stays low.
- R8: Any other low-bit code selects a one-bit bypass path. Capture loads 0 into it, and after one shift TDO equals the TDI bit shifted in.
- R9: Shifting is LSB first. TDO always shows bit 0 of the shift stage, and TDI enters at the top bit of the selected register's length.
- R10: When capture and update strike in the same cycle, the register takes the shift stage's previous contents and the stage takes the register's previous value.
- R11: tdo_oe is high only in cycles where shift_dr is high and the device is addressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial test data in |
| instr | input | IR_W | Current instruction; top bit is the device address |
| cascade_en | input | 1 | High when two devices share the scan path |
| is_extension | input | 1 | High when this device is the cascade extension |
| tdo | output | 1 | Serial test data out (bit 0 of the shift stage) |
| tdo_oe | output | 1 | Output enable for TDO |
| cfg_q | output | CFG_W | Configuration register contents |
| scratch_q | output | SCR_W | Scratchpad register contents |

## Verification
The two functions that can coincide are the writing of a register from the shift stage on update and the reloading of that same stage on capture. The bench raises both strobes in one cycle with the scratchpad selected. It then checks that the scratchpad holds the freshly shifted word, and that the following 32 shifts bring out the value the scratchpad held before that cycle. The behavioural model, which applies update from the stage's old contents, judges every cycle of the run as well.

// File: rtl/jrb_pkg.sv
package jrb_pkg;

    typedef enum logic [1:0] {
        SEL_BYP = 2'd0,
        SEL_ID  = 2'd1,
        SEL_CFG = 2'd2,
        SEL_SCR = 2'd3
    } sel_e;

endpackage

// File: rtl/jrb_decode.sv
module jrb_decode
    import jrb_pkg::*;
#(
    parameter int IR_W   = 4,
    parameter int OP_ID  = 1,
    parameter int OP_CFG = 2,
    parameter int OP_SCR = 3
) (
    input  logic [IR_W-1:0] instr,
    input  logic            cascade_en,
    input  logic            is_extension,
    output logic            addressed,
    output sel_e            sel
);
    localparam int OP_W = IR_W - 1;

    logic            own_addr;
    logic [OP_W-1:0] op;

    always_comb begin
        own_addr  = cascade_en & is_extension;
        addressed = (instr[IR_W-1] == own_addr);
        op        = instr[OP_W-1:0];
        if (op == OP_W'(OP_ID))       sel = SEL_ID;
        else if (op == OP_W'(OP_CFG)) sel = SEL_CFG;
        else if (op == OP_W'(OP_SCR)) sel = SEL_SCR;
        else                          sel = SEL_BYP;
    end

endmodule

// File: rtl/jrb_shift.sv
module jrb_shift #(
    parameter int SR_W  = 32,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             shf_en,
    input  logic             tdi,
    input  logic [LEN_W-1:0] len,
    input  logic [SR_W-1:0]  cap_val,
    output logic [SR_W-1:0]  stage_q
);
    typedef struct packed {
        logic [SR_W-1:0] sr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_en) begin
            st_d.sr = cap_val;
        end else if (shf_en) begin
            for (int i = 0; i < SR_W; i++) begin
                if (i + 1 < int'(len))       st_d.sr[i] = st_q.sr[i+1];
                else if (i + 1 == int'(len)) st_d.sr[i] = tdi;
                else                         st_d.sr[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_q = st_q.sr;

endmodule

// File: rtl/jrb_regs.sv
module jrb_regs #(
    parameter int CFG_W = 6,
    parameter int SCR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cfg,
    input  logic             wr_scr,
    input  logic [SCR_W-1:0] din,
    output logic [CFG_W-1:0] cfg_q,
    output logic [SCR_W-1:0] scr_q
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [SCR_W-1:0] scr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_cfg) r_d.cfg = din[CFG_W-1:0];
        if (wr_scr) r_d.scr = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_q = r_q.cfg;
    assign scr_q = r_q.scr;

endmodule

// File: rtl/jtag_regbank.sv
module jtag_regbank
    import jrb_pkg::*;
#(
    parameter int          IR_W   = 4,
    parameter int          CFG_W  = 6,
    parameter int          SCR_W  = 32,
    parameter int          REV_W  = 4,
    parameter int          FIX_W  = 4,
    parameter logic [3:0]  REV    = 4'h3,
    parameter logic [3:0]  FIXED  = 4'hA,
    parameter int          OP_ID  = 1,
    parameter int          OP_CFG = 2,
    parameter int          OP_SCR = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    input  logic [IR_W-1:0]  instr,
    input  logic             cascade_en,
    input  logic             is_extension,
    output logic             tdo,
    output logic             tdo_oe,
    output logic [CFG_W-1:0] cfg_q,
    output logic [SCR_W-1:0] scratch_q
);
    localparam int ID_W   = FIX_W + REV_W;
    localparam int MAX_A  = (ID_W > CFG_W) ? ID_W : CFG_W;
    localparam int SR_W   = (MAX_A > SCR_W) ? MAX_A : SCR_W;
    localparam int LEN_W  = $clog2(SR_W + 1);
    localparam logic [ID_W-1:0] ID_VAL = {FIXED[FIX_W-1:0], REV[REV_W-1:0]};

    logic             addressed;
    sel_e             sel;
    logic [SR_W-1:0]  stage;
    logic [SR_W-1:0]  cap_val;
    logic [LEN_W-1:0] len;
    logic             wr_cfg, wr_scr;

    jrb_decode #(
        .IR_W(IR_W), .OP_ID(OP_ID), .OP_CFG(OP_CFG), .OP_SCR(OP_SCR)
    ) u_dec (
        .instr(instr), .cascade_en(cascade_en), .is_extension(is_extension),
        .addressed(addressed), .sel(sel)
    );

    always_comb begin
        case (sel)
            SEL_ID:  begin cap_val = SR_W'(ID_VAL);    len = LEN_W'(ID_W);  end
            SEL_CFG: begin cap_val = SR_W'(cfg_q);     len = LEN_W'(CFG_W); end
            SEL_SCR: begin cap_val = SR_W'(scratch_q); len = LEN_W'(SCR_W); end
            default: begin cap_val = '0;               len = LEN_W'(1);     end
        endcase
        wr_cfg = addressed & update_dr & (sel == SEL_CFG);
        wr_scr = addressed & update_dr & (sel == SEL_SCR);
    end

    jrb_shift #(.SR_W(SR_W), .LEN_W(LEN_W)) u_sh (
        .clk(clk), .rst_n(rst_n),
        .cap_en(addressed & capture_dr), .shf_en(addressed & shift_dr),
        .tdi(tdi), .len(len), .cap_val(cap_val), .stage_q(stage)
    );

    jrb_regs #(.CFG_W(CFG_W), .SCR_W(SCR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_cfg(wr_cfg), .wr_scr(wr_scr),
        .din(stage[SCR_W-1:0]), .cfg_q(cfg_q), .scr_q(scratch_q)
    );

    assign tdo    = stage[0];
    assign tdo_oe = addressed & shift_dr;

endmodule

// File: rtl/jtag_regbank_chk.sv
module jtag_regbank_chk #(
    parameter int IR_W   = 4,
    parameter int CFG_W  = 6,
    parameter int SCR_W  = 32,
    parameter int OP_ID  = 1,
    parameter int OP_CFG = 2,
    parameter int OP_SCR = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic             tdi,
    input logic [IR_W-1:0]  instr,
    input logic             cascade_en,
    input logic             is_extension,
    input logic             tdo,
    input logic             tdo_oe,
    input logic [CFG_W-1:0] cfg_q,
    input logic [SCR_W-1:0] scratch_q
);
    logic           hit;
    logic [IR_W-2:0] op;
    logic           is_byp;
    assign op     = instr[IR_W-2:0];
    assign hit    = (instr[IR_W-1] == (cascade_en & is_extension));
    assign is_byp = (op != (IR_W-1)'(OP_ID)) && (op != (IR_W-1)'(OP_CFG)) &&
                    (op != (IR_W-1)'(OP_SCR));

    AST_OE_ONLY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        tdo_oe |-> shift_dr); // R11
    AST_MASTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_en && !is_extension && instr[IR_W-1]) |-> !tdo_oe); // R1
    AST_SINGLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cascade_en && instr[IR_W-1]) |-> !tdo_oe); // R2
    AST_UNADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(cfg_q) && $stable(scratch_q) && $stable(tdo))); // R7
    AST_ID_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && update_dr && op == (IR_W-1)'(OP_ID)) |=>
        ($stable(cfg_q) && $stable(scratch_q))); // R4
    AST_BYPASS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && is_byp && shift_dr && !capture_dr) |=> (tdo == $past(tdi))); // R8

endmodule

bind jtag_regbank jtag_regbank_chk #(
    .IR_W(IR_W), .CFG_W(CFG_W), .SCR_W(SCR_W),
    .OP_ID(OP_ID), .OP_CFG(OP_CFG), .OP_SCR(OP_SCR)
) u_chk (.*);

// File: tb/jtag_regbank_tb.sv
`timescale 1ns/1ps
module jtag_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic [3:0]  instr = 4'b0001;
    logic        cascade_en = 0, is_extension = 0;
    logic        tdo, tdo_oe;
    logic [5:0]  cfg_q;
    logic [31:0] scratch_q;

    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    jtag_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .instr(instr), .cascade_en(cascade_en),
        .is_extension(is_extension), .tdo(tdo), .tdo_oe(tdo_oe),
        .cfg_q(cfg_q), .scratch_q(scratch_q)
    );

    // behavioural reference model
    logic [5:0]  m_cfg;
    logic [31:0] m_scr;
    logic [31:0] m_sr;

    function automatic bit m_addr();
        return instr[3] == (cascade_en && is_extension);
    endfunction

    function automatic int m_width();
        case (instr[2:0])
            3'd1: return 8;
            3'd2: return 6;
            3'd3: return 32;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] m_capval();
        case (instr[2:0])
            3'd1: return 32'hA3;
            3'd2: return {26'd0, m_cfg};
            3'd3: return m_scr;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic [63:0] t;
        logic [31:0] old;
        int w;
        if (!rst_n) begin
            m_cfg = 0; m_scr = 0; m_sr = 0;
        end else if (m_addr()) begin
            old = m_sr;
            w = m_width();
            if (capture_dr) m_sr = m_capval();
            else if (shift_dr) begin
                t = ({32'd0, old} >> 1) & ((64'd1 << (w - 1)) - 64'd1);
                t = t | ({63'd0, tdi} << (w - 1));
                m_sr = t[31:0];
            end
            if (update_dr && instr[2:0] == 3'd2) m_cfg = old[5:0];
            if (update_dr && instr[2:0] == 3'd3) m_scr = old;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(tdo_oe == (m_addr() && shift_dr), "R11 tdo_oe", {31'd0, tdo_oe},
                {31'd0, m_addr() && shift_dr});
            chk(tdo == m_sr[0], "R9 tdo", {31'd0, tdo}, {31'd0, m_sr[0]});
            chk(cfg_q == m_cfg, "R5 cfg_q", {26'd0, cfg_q}, {26'd0, m_cfg});
            chk(scratch_q == m_scr, "R6 scratch_q", scratch_q, m_scr);
        end
    end

    task automatic cyc(input logic c, input logic s, input logic u, input logic d);
        capture_dr = c; shift_dr = s; update_dr = u; tdi = d;
        @(posedge clk); #2;
    endtask

    // capture, shift w bits LSB first, update, idle; returns bits seen on tdo
    task automatic scan(input int w, input logic [31:0] din, output logic [31:0] dout,
                        output bit oe_seen);
        dout = 0; oe_seen = 0;
        cyc(1, 0, 0, 0);
        for (int i = 0; i < w; i++) begin
            dout[i] = tdo;
            capture_dr = 0; shift_dr = 1; update_dr = 0; tdi = din[i];
            #1;
            if (tdo_oe) oe_seen = 1;
            @(posedge clk); #2;
        end
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
    endtask

    logic [31:0] got;
    bit          oe;

    initial begin
        #1000000;
        fails++; tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #22 rst_n = 1'b1;
        @(posedge clk); #2;
        chk(cfg_q == 0 && scratch_q == 0 && !tdo_oe, "R6 reset", scratch_q, 0);

        // single mode identity
        instr = 4'b0001;
        scan(8, 32'h55, got, oe);
        chk(got[7:0] == 8'hA3, "R3 id capture", got, 32'hA3);
        chk(cfg_q == 0 && scratch_q == 0, "R4 id write ignored", scratch_q, 0);
        scan(8, 32'h00, got, oe);
        chk(got[7:0] == 8'hA3, "R4 id unchanged", got, 32'hA3);

        // configuration
        instr = 4'b0010;
        scan(6, 32'h2D, got, oe);
        chk(cfg_q == 6'h2D, "R5 cfg write", {26'd0, cfg_q}, 32'h2D);
        scan(6, 32'h2D, got, oe);
        chk(got[5:0] == 6'h2D, "R5 cfg readback", got, 32'h2D);

        // scratchpad
        instr = 4'b0011;
        scan(32, 32'hDEADBEEF, got, oe);
        chk(scratch_q == 32'hDEADBEEF, "R6 scratch write", scratch_q, 32'hDEADBEEF);

        // single mode, top bit set, extension flag ignored
        is_extension = 1;
        instr = 4'b1010;
        scan(6, 32'h11, got, oe);
        chk(cfg_q == 6'h2D, "R2 cfg untouched", {26'd0, cfg_q}, 32'h2D);
        chk(!oe, "R7 oe low unaddressed", {31'd0, oe}, 0);
        instr = 4'b0010;
        scan(6, 32'h2D, got, oe);
        chk(oe, "R2 single answers msb0", {31'd0, oe}, 1);

        // cascade master
        cascade_en = 1; is_extension = 0;
        instr = 4'b1011;
        scan(32, 32'h12345678, got, oe);
        chk(scratch_q == 32'hDEADBEEF && !oe, "R1 master ignores msb1", scratch_q,
            32'hDEADBEEF);
        instr = 4'b0011;
        scan(32, 32'hCAFEF00D, got, oe);
        chk(got == 32'hDEADBEEF, "R9 scratch LSB-first readback", got, 32'hDEADBEEF);
        chk(scratch_q == 32'hCAFEF00D, "R1 master answers msb0", scratch_q, 32'hCAFEF00D);

        // cascade extension
        is_extension = 1;
        instr = 4'b0010;
        scan(6, 32'h07, got, oe);
        chk(cfg_q == 6'h2D && !oe, "R1 extension ignores msb0", {26'd0, cfg_q}, 32'h2D);
        instr = 4'b1010;
        scan(6, 32'h31, got, oe);
        chk(cfg_q == 6'h31, "R1 extension answers msb1", {26'd0, cfg_q}, 32'h31);

        // bypass
        cascade_en = 0; is_extension = 0;
        instr = 4'b0111;
        cyc(1, 0, 0, 0);
        chk(tdo == 1'b0, "R8 bypass capture zero", {31'd0, tdo}, 0);
        cyc(0, 1, 0, 1);
        chk(tdo == 1'b1, "R8 bypass one bit", {31'd0, tdo}, 1);
        cyc(0, 1, 0, 0);
        chk(tdo == 1'b0, "R8 bypass follows tdi", {31'd0, tdo}, 0);
        cyc(0, 0, 0, 0);

        // capture and update together
        instr = 4'b0011;
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 32; i++) cyc(0, 1, 0, (32'h0F1E2D3C >> i) & 1);
        cyc(1, 0, 1, 0);
        chk(scratch_q == 32'h0F1E2D3C, "R10 update wins register", scratch_q,
            32'h0F1E2D3C);
        got = 0;
        for (int i = 0; i < 32; i++) begin
            got[i] = tdo;
            cyc(0, 1, 0, 0);
        end
        chk(got == 32'hCAFEF00D, "R10 capture took old value", got, 32'hCAFEF00D);
        cyc(0, 0, 0, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule